// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block guards the frequency-select code that a clock synthesizer uses. While the watchdog is off, the normal frequency code passes straight through. Once the host enables it, the block counts down a timeout. The timeout is a host-programmed 8-bit unit count multiplied by a unit length that is itself counted in millisecond ticks. The host must service the watchdog before the count runs out. If the timeout lapses, for example because an aggressive clock setting has hung the system, the block enters an alarm state. In that state it replaces the normal code with a stored safe code, raises a sticky alarm flag for the host to read, and emits one active-low system reset pulse of fixed length.

The reset output is meant to drive an open-drain pull-down. A low level means the pull-down is on, and a high level means it is released. The alarm stays set, and the safe code stays selected, until the host clears the alarm or disables the watchdog. The unit length and the pulse width are parameters in tick counts, so the same logic serves 580 ms units and a 32 ms pulse on silicon, and much shorter values in simulation.

Top module: `ocwd_top`

## Requirements
- R1: After reset the alarm flag is 0, the reset output is 1 (released) and the selected code equals the normal code.
- R2: While the enable input is 0 no alarm is raised and no reset pulse occurs, however many ticks arrive.
- R3: With a timeout count N (1..255), the alarm rises on the clock edge of the (N x UNIT_TICKS)-th tick after the watchdog was enabled, and not earlier.
- R4: A one-cycle service strobe while running reloads the countdown, so the alarm comes N x UNIT_TICKS ticks after the strobe.
- R5: A timeout-write strobe while running reloads the countdown from the timeout value present at that strobe.
- R6: A timeout count of 0 means 256 units, not an immediate alarm.
- R7: The selected code equals the safe code whenever the alarm flag is 1, and equals the normal code otherwise, following both inputs as they change.
- R8: On entering alarm the reset output goes low on the same edge and stays low for exactly PULSE_TICKS further ticks, then releases.
- R9: The alarm is sticky. Service strobes and further ticks while in alarm neither clear it nor produce a second reset pulse.
- R10: A one-cycle clear strobe during alarm, or dropping the enable, clears the alarm on the next edge. After a clear the countdown restarts from the full timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base strobe (one per millisecond on silicon) |
| wd_en_i | input | 1 | Watchdog run enable |
| timeout_i | input | CNT_W | Timeout in units; 0 means 2^CNT_W |
| timeout_wr_i | input | 1 | Strobe: timeout value was written, reload countdown |
| service_i | input | 1 | Strobe: host service, reload countdown |
| alarm_clr_i | input | 1 | Strobe: clear the alarm and resume counting |
| norm_code_i | input | CODE_W | Normal frequency-select code |
| safe_code_i | input | CODE_W | Fallback frequency-select code |
| sel_code_o | output | CODE_W | Active frequency-select code |
| alarm_o | output | 1 | Alarm status flag (1 = timed out) |
| sys_rst_n_o | output | 1 | Active-low reset pulse for an open-drain pull-down |

## Verification
The hardest case to reach is the 256-unit window selected by a zero count. It needs more than a thousand ticks with no stray reload, so the bench shrinks the unit to four ticks and checks the alarm one tick before and exactly at the boundary. The tick-exact expiry and pulse boundaries depend on tick strobes that never coincide with a reload strobe. To get this, each scenario task spaces its ticks one idle cycle apart and drives service, write and clear strobes only in cycles that carry no tick. The sticky-alarm case runs the full pulse out and then keeps ticking and servicing, to show that no second pulse follows.

// File: rtl/ocwd_pkg.sv
// Package: shared types for the overclock watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package ocwd_pkg;

    // Watchdog operating state.
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_RUN   = 2'd1,
        WD_ALARM = 2'd2
    } wd_state_e;

endpackage

// File: rtl/ocwd_prescale.sv
// Module: divides the tick strobe into unit strobes.
// Emits unit_stb_o on the tick that completes UNIT_TICKS ticks since the last clear.
// Assumes: UNIT_TICKS >= 2; clear_i has priority over counting.
module ocwd_prescale #(
    parameter int UNIT_TICKS = 580
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic unit_stb_o
);
    localparam int PRE_W = $clog2(UNIT_TICKS);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

    logic [PRE_W-1:0] pre_q;

    // Count ticks within the current unit, wrapping at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pre_q <= '0;
        end else if (run_i && tick_i) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    // Flag the tick that closes a unit.
    assign unit_stb_o = run_i && tick_i && !clear_i && (pre_q == PRE_LAST);

endmodule

// File: rtl/ocwd_units.sv
// Module: unit down-counter for the watchdog timeout.
// A zero programmed count loads 2^CNT_W units. expire_o flags the step that
// consumes the final unit.
// Assumes: load_i has priority over step_i.
module ocwd_units #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             step_i,
    output logic             expire_o
);
    localparam int UC_W = CNT_W + 1;

    logic [UC_W-1:0] units_q;
    logic [UC_W-1:0] load_val;

    // Map a zero count onto the full range.
    always_comb begin
        load_val = (count_i == '0) ? UC_W'(1) << CNT_W : {1'b0, count_i};
    end

    // Load or step the remaining-unit count.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            units_q <= load_val;
        end else if (step_i && units_q != '0) begin
            units_q <= units_q - 1'b1;
        end
    end

    // The step from one remaining unit is the expiry.
    assign expire_o = step_i && !load_i && (units_q == UC_W'(1));

endmodule

// File: rtl/ocwd_pulse.sv
// Module: fixed-width active-low reset pulse timer.
// Low from the fire_i edge for PULSE_TICKS further ticks.
// Assumes: PULSE_TICKS >= 1; output feeds an open-drain pull-down.
module ocwd_pulse #(
    parameter int PULSE_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic tick_i,
    output logic pulse_n_o
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] left_q;

    // Arm on fire, count down one per tick until released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire_i) begin
            left_q <= PW'(PULSE_TICKS);
        end else if (tick_i && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Released whenever no ticks remain.
    assign pulse_n_o = (left_q == '0);

endmodule

// File: rtl/ocwd_top.sv
// Module: overclock watchdog with safe-frequency fallback.
// Counts timeout_i units of UNIT_TICKS ticks while enabled. On expiry it latches
// the alarm, selects safe_code_i and fires one reset pulse of PULSE_TICKS ticks.
// Assumes: all strobes are synchronous one-cycle pulses; reload beats a
// coincident tick.
module ocwd_top #(
    parameter int CNT_W       = 8,
    parameter int CODE_W      = 4,
    parameter int UNIT_TICKS  = 580,
    parameter int PULSE_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wd_en_i,
    input  logic [CNT_W-1:0]  timeout_i,
    input  logic              timeout_wr_i,
    input  logic              service_i,
    input  logic              alarm_clr_i,
    input  logic [CODE_W-1:0] norm_code_i,
    input  logic [CODE_W-1:0] safe_code_i,
    output logic [CODE_W-1:0] sel_code_o,
    output logic              alarm_o,
    output logic              sys_rst_n_o
);
    import ocwd_pkg::*;

    wd_state_e state_q, state_d;
    logic      running, reload, unit_stb, expire;

    assign running = (state_q == WD_RUN);
    // Reload whenever not counting, or on any host strobe.
    assign reload  = !running || service_i || timeout_wr_i;

    ocwd_prescale #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (reload),
        .run_i      (running),
        .tick_i     (tick_i),
        .unit_stb_o (unit_stb)
    );

    ocwd_units #(.CNT_W(CNT_W)) u_units (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (reload),
        .count_i  (timeout_i),
        .step_i   (unit_stb),
        .expire_o (expire)
    );

    ocwd_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (expire),
        .tick_i    (tick_i),
        .pulse_n_o (sys_rst_n_o)
    );

    // Next-state decision for the watchdog mode.
    always_comb begin
        state_d = state_q;
        if (!wd_en_i) begin
            state_d = WD_IDLE;
        end else begin
            unique case (state_q)
                WD_IDLE:  state_d = WD_RUN;
                WD_RUN:   state_d = expire ? WD_ALARM : WD_RUN;
                WD_ALARM: state_d = alarm_clr_i ? WD_RUN : WD_ALARM;
                default:  state_d = WD_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    // Status flag and frequency-code substitution.
    assign alarm_o    = (state_q == WD_ALARM);
    assign sel_code_o = alarm_o ? safe_code_i : norm_code_i;

endmodule

// File: rtl/ocwd_checker.sv
// Module: port-level properties of the overclock watchdog, bound to ocwd_top.
// Assumes: synchronous active-low reset on rst_n.
module ocwd_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wd_en_i,
    input logic              service_i,
    input logic              alarm_clr_i,
    input logic [CODE_W-1:0] norm_code_i,
    input logic [CODE_W-1:0] safe_code_i,
    input logic [CODE_W-1:0] sel_code_o,
    input logic              alarm_o,
    input logic              sys_rst_n_o
);
    // R2: disabling leaves no alarm on the next edge.
    p_no_alarm_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en_i |=> !alarm_o);

    // R7: safe code while alarmed.
    p_safe_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> sel_code_o == safe_code_i);

    // R7: normal code otherwise.
    p_norm_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_o |-> sel_code_o == norm_code_i);

    // R8: entering alarm pulls reset low at once.
    p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> !sys_rst_n_o);

    // R8: a reset pulse only begins with a new alarm.
    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n_o) |-> $rose(alarm_o));

    // R9: alarm holds against service while enabled and not cleared.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && wd_en_i && !alarm_clr_i) |=> alarm_o);

    // R10: a clear strobe drops the alarm.
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && alarm_clr_i) |=> !alarm_o);

endmodule

bind ocwd_top ocwd_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_en_i     (wd_en_i),
    .service_i   (service_i),
    .alarm_clr_i (alarm_clr_i),
    .norm_code_i (norm_code_i),
    .safe_code_i (safe_code_i),
    .sel_code_o  (sel_code_o),
    .alarm_o     (alarm_o),
    .sys_rst_n_o (sys_rst_n_o)
);

// File: tb/ocwd_top_tb.sv
module ocwd_top_tb;
    localparam int CNT_W  = 8;
    localparam int CODE_W = 4;
    localparam int UNIT   = 4;
    localparam int PULSE  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0, wd_en_i = 1'b0;
    logic [CNT_W-1:0]  timeout_i = 8'd3;
    logic              timeout_wr_i = 1'b0, service_i = 1'b0, alarm_clr_i = 1'b0;
    logic [CODE_W-1:0] norm_code_i = 4'h3, safe_code_i = 4'hC;
    logic [CODE_W-1:0] sel_code_o;
    logic              alarm_o, sys_rst_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ocwd_top #(.CNT_W(CNT_W), .CODE_W(CODE_W), .UNIT_TICKS(UNIT), .PULSE_TICKS(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wd_en_i(wd_en_i),
        .timeout_i(timeout_i), .timeout_wr_i(timeout_wr_i), .service_i(service_i),
        .alarm_clr_i(alarm_clr_i), .norm_code_i(norm_code_i), .safe_code_i(safe_code_i),
        .sel_code_o(sel_code_o), .alarm_o(alarm_o), .sys_rst_n_o(sys_rst_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; @(negedge clk);
            tick_i = 1'b0; @(negedge clk);
        end
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1; @(negedge clk);
        s = 1'b0; @(negedge clk);
    endtask

    task automatic start(input int n);
        timeout_i = CNT_W'(n);
        wd_en_i = 1'b1; @(negedge clk);
    endtask

    task automatic stop();
        wd_en_i = 1'b0; @(negedge clk);
        ticks(PULSE);
    endtask

    task automatic t_reset();
        chk("R1 alarm", alarm_o, 0);
        chk("R1 rst_n", sys_rst_n_o, 1);
        chk("R1 sel", sel_code_o, norm_code_i);
    endtask

    task automatic t_disabled();
        timeout_i = 8'd1;
        ticks(60);
        chk("R2 alarm", alarm_o, 0);
        chk("R2 rst_n", sys_rst_n_o, 1);
    endtask

    task automatic t_expiry();
        start(3);
        ticks(3*UNIT - 1);
        chk("R3 before", alarm_o, 0);
        ticks(1);
        chk("R3 at", alarm_o, 1);
        chk("R8 low at alarm", sys_rst_n_o, 0);
        chk("R7 safe", sel_code_o, 4'hC);
        safe_code_i = 4'h9; #1;
        chk("R7 safe follows", sel_code_o, 4'h9);
        ticks(PULSE - 1);
        chk("R8 still low", sys_rst_n_o, 0);
        ticks(1);
        chk("R8 released", sys_rst_n_o, 1);
        stop();
        chk("R10 disable clears", alarm_o, 0);
        chk("R7 norm", sel_code_o, norm_code_i);
        safe_code_i = 4'hC;
    endtask

    task automatic t_service();
        start(2);
        ticks(6);
        strobe(service_i);
        ticks(2*UNIT - 1);
        chk("R4 before", alarm_o, 0);
        ticks(1);
        chk("R4 at", alarm_o, 1);
        stop();
    endtask

    task automatic t_write();
        start(5);
        ticks(3);
        timeout_i = 8'd2;
        strobe(timeout_wr_i);
        ticks(2*UNIT - 1);
        chk("R5 before", alarm_o, 0);
        ticks(1);
        chk("R5 at", alarm_o, 1);
        stop();
    endtask

    task automatic t_zero();
        start(0);
        ticks(256*UNIT - 1);
        chk("R6 before", alarm_o, 0);
        ticks(1);
        chk("R6 at", alarm_o, 1);
        stop();
    endtask

    task automatic t_sticky_clear();
        start(1);
        ticks(UNIT);
        chk("R9 alarm", alarm_o, 1);
        ticks(PULSE);
        strobe(service_i);
        ticks(3*UNIT);
        chk("R9 still alarm", alarm_o, 1);
        chk("R9 no 2nd pulse", sys_rst_n_o, 1);
        norm_code_i = 4'h5; #1;
        chk("R7 norm ignored", sel_code_o, 4'hC);
        timeout_i = 8'd2;
        strobe(alarm_clr_i);
        chk("R10 cleared", alarm_o, 0);
        chk("R7 norm back", sel_code_o, 4'h5);
        ticks(2*UNIT - 1);
        chk("R10 full restart before", alarm_o, 0);
        ticks(1);
        chk("R10 full restart at", alarm_o, 1);
        stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_expiry();
        t_service();
        t_write();
        t_zero();
        t_sticky_clear();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule